// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Overlap and Lock Indication

This block compares two divided pulse trains, a reference and a divided oscillator, and decides which one is ahead. It drives a source enable and a sink enable for a charge pump, and a high-impedance flag for when neither is on. Rising edges on both inputs are sampled by a fast internal clock. The first edge sets its own side. The second edge sets the other side. Once both sides are set, they stay set together for a programmable number of fast-clock cycles and are then cleared together. This enforced overlap removes the dead zone near zero phase error.

A polarity control exchanges the two enables, which reverses the sign of the detector gain. A lock indication goes low while the detector is correcting and rests high when the loop is balanced. It therefore forms a pulse-width image of the phase error. At the longest overlap setting, the overlap itself also pulls the lock line low, so the line never rests high. A 3-bit charge-pump current code passes through unchanged. In standby the detector discards its state, turns both enables off and parks the lock line high.

All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `pfd_abl`

## Requirements
- R1: With `pol_pos_i`=1, a rising edge on `ref_i` that arrives first asserts `up_en_o` from the clock edge that samples it. `up_en_o` then stays high until the overlap period ends.
- R2: With `pol_pos_i`=1, a rising edge on `vco_i` that arrives first asserts `down_en_o` from the clock edge that samples it. `down_en_o` then stays high until the overlap period ends.
- R3: After the lagging edge is sampled, both enables are high for exactly N clock cycles and then both go low. Edges that are sampled in the same cycle produce only this N-cycle overlap.
- R4: `abl_code_i` selects N. The encodings are 0→1, 1→4, 2→8 and 3→10 cycles.
- R5: `pd_hiz_o` is high exactly when neither enable is asserted.
- R6: With `pol_pos_i`=0, the two enables are exchanged: a leading reference drives `down_en_o` and a leading oscillator drives `up_en_o`.
- R7: For `abl_code_i` values 0 to 2, `ld_o` is low exactly when one enable is asserted without the other. It is high during the overlap and when idle.
- R8: For `abl_code_i`=3, `ld_o` is low whenever any enable is asserted, including the overlap.
- R9: While `standby_i`=1, both enables are 0, `pd_hiz_o`=1 and `ld_o`=1, and input edges are ignored. A correction that was in progress is discarded, so the outputs stay idle after standby is released until a new edge arrives.
- R10: `icp_sel_o` always equals `icp_code_i`. The codes 0 to 7 select 0.175, 0.25, 0.35, 0.5, 0.7, 1.0, 1.4 and 2.0 mA.
- R11: During and after reset, both enables are 0, `pd_hiz_o`=1 and `ld_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Divided reference pulse |
| vco_i | input | 1 | Divided oscillator pulse |
| pol_pos_i | input | 1 | 1 = normal gain sign, 0 = enables exchanged |
| abl_code_i | input | 2 | Overlap length select |
| icp_code_i | input | 3 | Charge-pump current code |
| standby_i | input | 1 | Standby: detector idle and cleared |
| up_en_o | output | 1 | Source current enable |
| down_en_o | output | 1 | Sink current enable |
| pd_hiz_o | output | 1 | Pump output high impedance |
| icp_sel_o | output | 3 | Current code passed to the pump |
| ld_o | output | 1 | Lock indication, low while correcting |

## Verification
The bench drives the lead/lag gap across every overlap code, including edges sampled in the same cycle and a gap longer than the overlap. A design with a counter off by one would stretch or shorten the overlap and misplace the falling edge of both enables. Runs with the polarity bit cleared catch a design that ignores it or exchanges only one side. Runs at the longest code catch lock gating that stays active and leaves the lock line high during the overlap. A standby asserted mid-correction and then released with the inputs still high catches a design that merely masks its outputs and resumes the stale correction afterwards.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  // Overlap length selector; the top code also stops lock gating.
  typedef enum logic [1:0] {
    ABL_SHORT  = 2'd0,
    ABL_MID    = 2'd1,
    ABL_LONG   = 2'd2,
    ABL_NOGATE = 2'd3
  } abl_code_e;

  // Detector state, independent of output polarity.
  typedef struct packed {
    logic lead_ref; // reference side set
    logic lead_vco; // oscillator side set
  } pd_state_t;
endpackage

// File: rtl/pfd_edge.sv
`timescale 1ns/1ps
module pfd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
module pfd_core #(
  parameter int unsigned ABL_CYC0 = 1,
  parameter int unsigned ABL_CYC1 = 4,
  parameter int unsigned ABL_CYC2 = 8,
  parameter int unsigned ABL_CYC3 = 10,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                standby_i,
  input  logic                ref_rise_i,
  input  logic                vco_rise_i,
  input  pfd_pkg::abl_code_e  abl_code_i,
  output pfd_pkg::pd_state_t  st_o
);
  import pfd_pkg::*;

  pd_state_t        st_q, st_d;
  logic [CNT_W-1:0] ovl_cnt_q;
  logic [CNT_W-1:0] lim;
  logic             both, clr;

  always_comb begin
    unique case (abl_code_i)
      ABL_SHORT: lim = CNT_W'(ABL_CYC0);
      ABL_MID:   lim = CNT_W'(ABL_CYC1);
      ABL_LONG:  lim = CNT_W'(ABL_CYC2);
      default:   lim = CNT_W'(ABL_CYC3);
    endcase
  end

  assign both = st_q.lead_ref & st_q.lead_vco;
  assign clr  = both && (ovl_cnt_q == lim - 1'b1);

  always_comb begin
    if (standby_i) begin
      st_d = '0;
    end else begin
      st_d.lead_ref = (st_q.lead_ref & ~clr) | ref_rise_i;
      st_d.lead_vco = (st_q.lead_vco & ~clr) | vco_rise_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= '0;
      ovl_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (standby_i || clr || !both) ovl_cnt_q <= '0;
      else                           ovl_cnt_q <= ovl_cnt_q + 1'b1;
    end
  end

  assign st_o = st_q;

  AST_REF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_rise_i && !standby_i) |=> st_q.lead_ref); // R1
  AST_VCO_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vco_rise_i && !standby_i) |=> st_q.lead_vco); // R2
  AST_OVL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !ref_rise_i && !vco_rise_i && !standby_i) |=> (!st_q.lead_ref && !st_q.lead_vco)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both |-> (ovl_cnt_q < lim)); // R4
  AST_STBY_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!st_q.lead_ref && !st_q.lead_vco)); // R9
endmodule

// File: rtl/pfd_lock.sv
`timescale 1ns/1ps
module pfd_lock (
  input  pfd_pkg::pd_state_t st_i,
  input  pfd_pkg::abl_code_e abl_code_i,
  input  logic               standby_i,
  output logic               ld_o
);
  import pfd_pkg::*;

  logic one_sided, any_on;

  assign one_sided = st_i.lead_ref ^ st_i.lead_vco;
  assign any_on    = st_i.lead_ref | st_i.lead_vco;

  always_comb begin
    if (standby_i)                    ld_o = 1'b1;
    else if (abl_code_i == ABL_NOGATE) ld_o = ~any_on;
    else                              ld_o = ~one_sided;
  end
endmodule

// File: rtl/pfd_abl.sv
`timescale 1ns/1ps
module pfd_abl #(
  parameter int unsigned ABL_CYC0 = 1,
  parameter int unsigned ABL_CYC1 = 4,
  parameter int unsigned ABL_CYC2 = 8,
  parameter int unsigned ABL_CYC3 = 10,
  parameter int unsigned ICP_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             vco_i,
  input  logic             pol_pos_i,
  input  logic [1:0]       abl_code_i,
  input  logic [ICP_W-1:0] icp_code_i,
  input  logic             standby_i,
  output logic             up_en_o,
  output logic             down_en_o,
  output logic             pd_hiz_o,
  output logic [ICP_W-1:0] icp_sel_o,
  output logic             ld_o
);
  import pfd_pkg::*;

  localparam int unsigned MAX01 = (ABL_CYC0 > ABL_CYC1) ? ABL_CYC0 : ABL_CYC1;
  localparam int unsigned MAX23 = (ABL_CYC2 > ABL_CYC3) ? ABL_CYC2 : ABL_CYC3;
  localparam int unsigned MAXC  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam int unsigned NIN   = 2;

  logic [NIN-1:0] in_vec, rise_vec;
  pd_state_t      st;
  abl_code_e      code;

  assign in_vec = {vco_i, ref_i};
  assign code   = abl_code_e'(abl_code_i);

  for (genvar g = 0; g < NIN; g++) begin : g_edge
    pfd_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (in_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  pfd_core #(
    .ABL_CYC0 (ABL_CYC0),
    .ABL_CYC1 (ABL_CYC1),
    .ABL_CYC2 (ABL_CYC2),
    .ABL_CYC3 (ABL_CYC3),
    .CNT_W    (CNT_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .standby_i  (standby_i),
    .ref_rise_i (rise_vec[0]),
    .vco_rise_i (rise_vec[1]),
    .abl_code_i (code),
    .st_o       (st)
  );

  pfd_lock u_lock (
    .st_i       (st),
    .abl_code_i (code),
    .standby_i  (standby_i),
    .ld_o       (ld_o)
  );

  assign up_en_o   = ~standby_i & (pol_pos_i ? st.lead_ref : st.lead_vco);
  assign down_en_o = ~standby_i & (pol_pos_i ? st.lead_vco : st.lead_ref);
  assign pd_hiz_o  = ~(up_en_o | down_en_o);
  assign icp_sel_o = icp_code_i;

  AST_STBY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> (ld_o && pd_hiz_o)); // R9
  AST_ONE_SIDE_LD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != ABL_NOGATE && (st.lead_ref ^ st.lead_vco) && !standby_i) |-> !ld_o); // R7
endmodule

// File: tb/pfd_abl_tb.sv
`timescale 1ns/1ps
module pfd_abl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_s, vco_s, pol, stby;
  logic [1:0] code;
  logic [2:0] icp;
  logic       up, dn, hiz, ld;
  logic [2:0] icp_o;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic [6:0] v;   // {up, dn, hiz, ld, icp[2:0]}
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  pfd_abl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ref_i      (ref_s),
    .vco_i      (vco_s),
    .pol_pos_i  (pol),
    .abl_code_i (code),
    .icp_code_i (icp),
    .standby_i  (stby),
    .up_en_o    (up),
    .down_en_o  (dn),
    .pd_hiz_o   (hiz),
    .icp_sel_o  (icp_o),
    .ld_o       (ld)
  );

  function automatic int ovl_len(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 10;
    endcase
  endfunction

  task automatic check(input logic [6:0] got, input logic [6:0] want, input string tag);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got up/dn/hiz/ld/icp=%b expected %b", tag, got, want);
    end
  endtask

  // Monitor: compares one queued expectation per cycle after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({up, dn, hiz, ld, icp_o}, e.v, e.tag);
      end
    end
  end

  task automatic step(input logic r, input logic v, input logic u, input logic d, input string tag);
    exp_t e;
    logic l;
    @(negedge clk);
    ref_s = r;
    vco_s = v;
    if (stby) l = 1'b1;
    else if (code == 2'd3) l = ~(u | d);
    else l = ~(u ^ d);
    e.v   = {u, d, ~(u | d), l, icp};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Leading input rises at cycle 0, lagging one at cycle k.
  task automatic run_case(input int k, input logic [1:0] c, input logic p,
                          input logic vco_first, input logic [2:0] ic, input string tag);
    int n;
    @(negedge clk);
    code = c; pol = p; icp = ic;
    n = ovl_len(c);
    for (int i = 0; i < k + n + 3; i++) begin
      logic lead, lag, rs, vs, rin, vin;
      lead = (i < k + n);
      lag  = (i >= k) && (i < k + n);
      rs   = vco_first ? lag : lead;
      vs   = vco_first ? lead : lag;
      rin  = vco_first ? (i >= k) : 1'b1;
      vin  = vco_first ? 1'b1 : (i >= k);
      step(rin, vin, p ? rs : vs, p ? vs : rs, tag);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0; ref_s = 0; vco_s = 0; pol = 1; stby = 0; code = 0; icp = 3'd5;
    repeat (3) @(negedge clk);
    check({up, dn, hiz, ld, icp_o}, {1'b0, 1'b0, 1'b1, 1'b1, 3'd5}, "R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({up, dn, hiz, ld, icp_o}, {1'b0, 1'b0, 1'b1, 1'b1, 3'd5}, "R11 after reset");

    run_case(3, 2'd0, 1'b1, 1'b0, 3'd0, "R1 R3 R4 R7 ref leads code0");
    run_case(3, 2'd1, 1'b1, 1'b0, 3'd1, "R1 R4 R7 ref leads code1");
    run_case(2, 2'd2, 1'b1, 1'b1, 3'd2, "R2 R4 R5 vco leads code2");
    run_case(4, 2'd3, 1'b1, 1'b1, 3'd3, "R2 R4 R8 vco leads code3");
    run_case(0, 2'd1, 1'b1, 1'b0, 3'd4, "R3 R7 same-cycle code1");
    run_case(0, 2'd3, 1'b1, 1'b0, 3'd6, "R3 R8 same-cycle code3");
    run_case(5, 2'd2, 1'b0, 1'b0, 3'd7, "R6 swapped ref leads");
    run_case(3, 2'd0, 1'b0, 1'b1, 3'd2, "R6 swapped vco leads");
    run_case(14, 2'd3, 1'b1, 1'b0, 3'd1, "R8 R10 long gap code3");

    // R9: edges in standby are ignored.
    @(negedge clk);
    code = 2'd1; pol = 1'b1; stby = 1'b1;
    step(1'b1, 1'b0, 0, 0, "R9 edge in standby");
    step(1'b1, 1'b0, 0, 0, "R9 edge in standby");
    step(1'b1, 1'b1, 0, 0, "R9 edge in standby");
    step(1'b0, 1'b0, 0, 0, "R9 edge in standby");
    @(negedge clk);
    stby = 1'b0;
    step(1'b0, 1'b0, 0, 0, "R9 idle after standby");
    // R9: a correction in progress is discarded.
    step(1'b1, 1'b0, 1, 0, "R9 ref leads before standby");
    step(1'b1, 1'b0, 1, 0, "R9 ref leads before standby");
    @(negedge clk);
    stby = 1'b1;
    step(1'b1, 1'b0, 0, 0, "R9 standby mid-correction");
    @(negedge clk);
    stby = 1'b0;
    step(1'b1, 1'b0, 0, 0, "R9 stale state discarded");
    step(1'b1, 1'b0, 0, 0, "R9 stale state discarded");
    step(1'b0, 1'b0, 0, 0, "R9 stale state discarded");
    // R10: the current code passes straight through.
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      icp = 3'(j);
      #1;
      check({up, dn, hiz, ld, icp_o}, {1'b0, 1'b0, 1'b1, 1'b1, 3'(j)}, "R10 current code");
    end

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got no finish, expected end of test");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule